// File: doc/BRIEF.md
# Extended SMRAM Address Decoder

This block sits between the host address path and the memory controller. For each host access it decides whether the access goes to DRAM or is forwarded to PCI, and it translates the address when DRAM is the target. An aliased window starting at `ALIAS_BASE` (default 256 MB) reaches two protected system-management regions:

- The legacy 640 KB to 1 MB segments, split into six 64 KB slices A to F.
- A reserved slice just below the top of installed memory. Its size is programmable.

Each slice is available only when its enables allow it. The C, D and E slices also require that shadowing does not claim them. The F slice requires the suspend/resume mode.

An access to an available protected slice is allowed only in two cases: system-management mode is active, or the open bit is set. An access that is not allowed is forwarded to PCI instead of DRAM and sets a sticky error flag. Software clears the flag by writing 1 to `err_clr_i`.

Ordinary host accesses below the top of memory map one-to-one into DRAM. The exception is the reserved slice, which is removed from the normal map while it is enabled. Every other address goes to PCI. The decode results are registered, so they appear one cycle after the access strobe.

Top module: `smram_xlat`

## Requirements
- R1: A host address `ALIAS_BASE + off`, with `off` in 0x000A0000..0x000FFFFF, hits DRAM at address `off` when its slice is available and the access is allowed. The slice number is `off[19:16]` (0xA..0xF).
- R2: The reserved slice covers DRAM `[mem_top_i - S, mem_top_i)`. S is 128 KB, 256 KB, 512 KB or 1 MB for `rsv_size_i` = 0, 1, 2 or 3. The slice is reached at host address `ALIAS_BASE + dram`.
- R3: Slices A and B are available exactly when `glob_en_i` and `hi_en_i` are both 1.
- R4: Slices C, D and E additionally need their shadow bit at 0. Bit 0 of `shadow_i` belongs to C, bit 1 to D and bit 2 to E.
- R5: Slice F additionally needs `f_resume_i` = 1.
- R6: The reserved slice is decoded only when `rsv_en_i` and `glob_en_i` are both 1.
- R7: An access to an available protected slice is not allowed when system-management mode is inactive and `open_i` = 0. Such an access raises `pci_fwd_o` instead of `dram_hit_o` and sets `err_o`.
- R8: `err_o` is sticky. It clears in the cycle after `err_clr_i` = 1. If a new error arrives in the same cycle as the clear, the flag stays set.
- R9: `smm_act_ni` is active-low. It is registered once, so it governs accesses issued from the next clock onward.
- R10: A host address below `mem_top_i` hits DRAM at the same address. While the reserved slice is enabled, its range is excluded from this rule and is forwarded to PCI.
- R11: Outputs are registered. One cycle after `valid_i` = 1, exactly one of `dram_hit_o` and `pci_fwd_o` is 1. Unavailable alias slices and all other addresses forward to PCI with no error. Without `valid_i`, both outputs and `dram_addr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Access strobe |
| addr_i | input | AW | Host address |
| smm_act_ni | input | 1 | System-management mode active, active low |
| open_i | input | 1 | Opens protected slices outside system-management mode |
| glob_en_i | input | 1 | Global protected-RAM enable |
| hi_en_i | input | 1 | Enable for the legacy A..F slices |
| rsv_en_i | input | 1 | Enable for the reserved top-of-memory slice |
| rsv_size_i | input | 2 | Reserved slice size code |
| mem_top_i | input | AW | Top of installed memory (byte address) |
| shadow_i | input | 3 | Shadowing claims slice C, D, E (bits 0..2) |
| f_resume_i | input | 1 | Slice F in suspend/resume mode |
| err_clr_i | input | 1 | Write-1-to-clear for the error flag |
| dram_hit_o | output | 1 | Access goes to DRAM |
| dram_addr_o | output | AW | Translated DRAM address |
| pci_fwd_o | output | 1 | Access forwarded to PCI |
| err_o | output | 1 | Sticky error flag |

## Verification
The bench sweeps every combination of the four size codes, the two authorization inputs and the three enables, crossed with four shadow/resume patterns. Under each combination it issues accesses to every 64 KB slice of the aliased low megabyte, and to addresses just inside and just outside each possible reserved-slice boundary, both aliased and plain.

This separates the effects of the three causes of availability (enable, shadowing, resume mode). It also separates allowed from refused access, and it pins the size decode, because each boundary step is probed on both sides.

Dedicated sequences check three further points: the one-cycle delay on the mode input, that a clear collides with a new error in favour of the error, and that a plain clear takes effect.

// File: rtl/smram_xlat_pkg.sv
package smram_xlat_pkg;
  typedef enum logic [1:0] {
    RT_NONE = 2'd0,
    RT_DRAM = 2'd1,
    RT_PCI  = 2'd2
  } route_e;

  localparam int unsigned SEG_LSB    = 16;   // 64 KB slice index
  localparam int unsigned RSV_MIN_B  = 17;   // log2(128 KB)
  localparam logic [3:0]  SEG_FIRST  = 4'hA;
  localparam logic [3:0]  SEG_C      = 4'hC;
endpackage

// File: rtl/smram_smm_sync.sv
module smram_smm_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smm_act_ni,
  output logic smm_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smm_o <= 1'b0;
    else         smm_o <= ~smm_act_ni;
  end
endmodule

// File: rtl/smram_region_dec.sv
module smram_region_dec
  import smram_xlat_pkg::*;
#(
  parameter int unsigned    AW         = 32,
  parameter logic [AW-1:0]  ALIAS_BASE = AW'(32'h1000_0000)
) (
  input  logic [AW-1:0] addr_i,
  input  logic          smm_i,
  input  logic          open_i,
  input  logic          glob_en_i,
  input  logic          hi_en_i,
  input  logic          rsv_en_i,
  input  logic [1:0]    rsv_size_i,
  input  logic [AW-1:0] mem_top_i,
  input  logic [2:0]    shadow_i,
  input  logic          f_resume_i,
  output route_e        route_o,
  output logic [AW-1:0] xlat_o,
  output logic          err_o
);
  localparam logic [AW-1:0] LEG_LO  = AW'(32'h000A_0000);
  localparam logic [AW-1:0] LEG_HI  = AW'(32'h0010_0000);
  localparam logic [AW-1:0] RSV_MIN = AW'(1) << RSV_MIN_B;

  logic [AW-1:0] rsv_bytes, rsv_base, off;
  logic          above, leg_on, rsv_on, in_leg, in_rsv, in_main, seg_ok, allowed;
  logic [3:0]    seg;
  logic [2:0]    cde_ok;

  assign rsv_bytes = RSV_MIN << rsv_size_i;
  assign rsv_base  = mem_top_i - rsv_bytes;
  assign off       = addr_i - ALIAS_BASE;
  assign above     = addr_i >= ALIAS_BASE;
  assign seg       = off[SEG_LSB+3:SEG_LSB];
  assign leg_on    = glob_en_i & hi_en_i;
  assign rsv_on    = glob_en_i & rsv_en_i;
  assign allowed   = smm_i | open_i;

  for (genvar g = 0; g < 3; g++) begin : g_cde
    assign cde_ok[g] = leg_on & ~shadow_i[g];
  end

  always_comb begin
    unique case (seg)
      4'hA, 4'hB:       seg_ok = leg_on;
      4'hC, 4'hD, 4'hE: seg_ok = cde_ok[2'(seg - SEG_C)];
      4'hF:             seg_ok = leg_on & f_resume_i;
      default:          seg_ok = 1'b0;
    endcase
  end

  assign in_leg  = above && off >= LEG_LO && off < LEG_HI && seg_ok;
  assign in_rsv  = rsv_on && above && off >= rsv_base && off < mem_top_i;
  assign in_main = (addr_i < mem_top_i) && !(rsv_on && addr_i >= rsv_base);

  always_comb begin
    route_o = RT_PCI;
    xlat_o  = '0;
    err_o   = 1'b0;
    if (in_leg || in_rsv) begin
      if (allowed) begin
        route_o = RT_DRAM;
        xlat_o  = off;
      end else begin
        err_o = 1'b1;
      end
    end else if (in_main) begin
      route_o = RT_DRAM;
      xlat_o  = addr_i;
    end
  end
endmodule

// File: rtl/smram_err_flag.sv
module smram_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_o <= 1'b0;
    else if (set_i) err_o <= 1'b1;
    else if (clr_i) err_o <= 1'b0;
  end

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clr_i) |=> err_o);
  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> err_o);
  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !err_o);
endmodule

// File: rtl/smram_xlat.sv
module smram_xlat
  import smram_xlat_pkg::*;
#(
  parameter int unsigned    AW         = 32,
  parameter logic [AW-1:0]  ALIAS_BASE = AW'(32'h1000_0000)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [AW-1:0] addr_i,
  input  logic          smm_act_ni,
  input  logic          open_i,
  input  logic          glob_en_i,
  input  logic          hi_en_i,
  input  logic          rsv_en_i,
  input  logic [1:0]    rsv_size_i,
  input  logic [AW-1:0] mem_top_i,
  input  logic [2:0]    shadow_i,
  input  logic          f_resume_i,
  input  logic          err_clr_i,
  output logic          dram_hit_o,
  output logic [AW-1:0] dram_addr_o,
  output logic          pci_fwd_o,
  output logic          err_o
);
  logic          smm_q, dec_err;
  route_e        route;
  logic [AW-1:0] xlat;

  smram_smm_sync u_sync (
    .clk_i, .rst_ni, .smm_act_ni, .smm_o(smm_q)
  );

  smram_region_dec #(.AW(AW), .ALIAS_BASE(ALIAS_BASE)) u_dec (
    .addr_i, .smm_i(smm_q), .open_i, .glob_en_i, .hi_en_i, .rsv_en_i,
    .rsv_size_i, .mem_top_i, .shadow_i, .f_resume_i,
    .route_o(route), .xlat_o(xlat), .err_o(dec_err)
  );

  smram_err_flag u_err (
    .clk_i, .rst_ni, .set_i(valid_i & dec_err), .clr_i(err_clr_i), .err_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dram_hit_o  <= 1'b0;
      pci_fwd_o   <= 1'b0;
      dram_addr_o <= '0;
    end else if (valid_i) begin
      dram_hit_o  <= (route == RT_DRAM);
      pci_fwd_o   <= (route != RT_DRAM);
      dram_addr_o <= (route == RT_DRAM) ? xlat : '0;
    end else begin
      dram_hit_o  <= 1'b0;
      pci_fwd_o   <= 1'b0;
      dram_addr_o <= '0;
    end
  end

  assert_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dram_hit_o && pci_fwd_o));
  assert_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!dram_hit_o && !pci_fwd_o && dram_addr_o == '0));
  assert_answer_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (dram_hit_o || pci_fwd_o));
  assert_refuse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dec_err) |=> (pci_fwd_o && err_o));
  assert_xlat_below_alias_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dram_hit_o |-> (dram_addr_o < ALIAS_BASE));
endmodule

// File: tb/smram_xlat_test.sv
`timescale 1ns/1ps
module smram_xlat_test;
  localparam logic [31:0] ALIAS = 32'h1000_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic        smm_act_ni = 1'b1;
  logic        open_i = 1'b0, glob_en_i = 1'b0, hi_en_i = 1'b0, rsv_en_i = 1'b0;
  logic [1:0]  rsv_size_i = '0;
  logic [31:0] mem_top_i = 32'h0080_0000;
  logic [2:0]  shadow_i = '0;
  logic        f_resume_i = 1'b0, err_clr_i = 1'b0;
  logic        dram_hit_o, pci_fwd_o, err_o;
  logic [31:0] dram_addr_o;

  int checks = 0, errors = 0;
  logic exp_err = 1'b0;

  always #5 clk_i = ~clk_i;

  smram_xlat uut (
    .clk_i, .rst_ni, .valid_i, .addr_i, .smm_act_ni, .open_i, .glob_en_i,
    .hi_en_i, .rsv_en_i, .rsv_size_i, .mem_top_i, .shadow_i, .f_resume_i,
    .err_clr_i, .dram_hit_o, .dram_addr_o, .pci_fwd_o, .err_o
  );

  task automatic model(input logic [31:0] a, input logic smm_on,
                       output logic h, output logic f, output logic [31:0] x,
                       output logic e, output string tag);
    logic [31:0] sz, base, off;
    logic leg_on, rsv_on, ok, prot;
    logic [3:0] s;
    sz = 32'h2_0000 << rsv_size_i;
    base = mem_top_i - sz;
    off = a - ALIAS;
    s = off[19:16];
    leg_on = glob_en_i & hi_en_i;
    rsv_on = glob_en_i & rsv_en_i;
    prot = 1'b0; tag = "R11";
    if (a >= ALIAS && off >= 32'hA_0000 && off < 32'h10_0000) begin
      if (s <= 4'hB)      begin ok = leg_on; tag = "R1 R3"; end
      else if (s <= 4'hE) begin ok = leg_on & ~shadow_i[s - 4'hC]; tag = "R1 R4"; end
      else                begin ok = leg_on & f_resume_i; tag = "R1 R5"; end
      prot = ok;
    end else if (a >= ALIAS && off >= base && off < mem_top_i) begin
      prot = rsv_on; tag = "R2 R6";
    end
    h = 1'b0; f = 1'b1; x = '0; e = 1'b0;
    if (prot) begin
      if (smm_on | open_i) begin h = 1'b1; f = 1'b0; x = off; end
      else begin e = 1'b1; tag = {tag, " R7"}; end
    end else if (a < mem_top_i && !(rsv_on && a >= base)) begin
      h = 1'b1; f = 1'b0; x = a; tag = "R10";
    end else if (a < mem_top_i) tag = "R10 R6";
  endtask

  task automatic check(input string tag, input logic h, input logic f,
                       input logic [31:0] x, input logic e);
    checks++;
    if (dram_hit_o !== h || pci_fwd_o !== f || dram_addr_o !== x || err_o !== e) begin
      errors++;
      $display("FAIL %s addr=%h act hit=%0d fwd=%0d xa=%h err=%0d exp hit=%0d fwd=%0d xa=%h err=%0d",
               tag, addr_i, dram_hit_o, pci_fwd_o, dram_addr_o, err_o, h, f, x, e);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic smm_on);
    logic h, f, e; logic [31:0] x; string tag;
    @(negedge clk_i);
    addr_i = a; valid_i = 1'b1;
    model(a, smm_on, h, f, x, e, tag);
    @(negedge clk_i);
    valid_i = 1'b0;
    if (e) exp_err = 1'b1;
    check(tag, h, f, x, exp_err);
  endtask

  task automatic clear_err();
    @(negedge clk_i); err_clr_i = 1'b1;
    @(negedge clk_i); err_clr_i = 1'b0;
    exp_err = 1'b0;
    check("R8 R11", 1'b0, 1'b0, '0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] offs [10];
    offs = '{32'hFFF0_0000 - 4, 32'hFFF0_0000, 32'hFFF8_0000 - 4, 32'hFFF8_0000,
             32'hFFFC_0000 - 4, 32'hFFFC_0000, 32'hFFFE_0000 - 4, 32'hFFFE_0000,
             32'hFFFF_FFFC, 32'h0};
    repeat (2) @(negedge clk_i);
    check("R11 reset", 1'b0, 1'b0, '0, 1'b0);
    rst_ni = 1'b1;

    // R9: mode input takes effect one cycle late
    glob_en_i = 1; hi_en_i = 1; open_i = 0;
    repeat (2) @(negedge clk_i);
    smm_act_ni = 1'b0; addr_i = ALIAS + 32'hA_0010; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0; exp_err = 1'b1;
    check("R9 pre", 1'b0, 1'b1, '0, 1'b1);
    access(ALIAS + 32'hA_0010, 1'b1);
    smm_act_ni = 1'b1;
    clear_err();

    // R8: clear colliding with a new error keeps the flag
    access(ALIAS + 32'hB_0000, 1'b0);
    @(negedge clk_i);
    addr_i = ALIAS + 32'hB_0004; valid_i = 1'b1; err_clr_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0; err_clr_i = 1'b0;
    check("R8 collide", 1'b0, 1'b1, '0, 1'b1);
    clear_err();
    @(negedge clk_i); err_clr_i = 1'b1;
    @(negedge clk_i); err_clr_i = 1'b0;
    check("R8 idle clear", 1'b0, 1'b0, '0, 1'b0);

    // Sweep
    for (int sz = 0; sz < 4; sz++)
      for (int au = 0; au < 4; au++)
        for (int en = 0; en < 8; en++)
          for (int sc = 0; sc < 4; sc++) begin
            rsv_size_i = 2'(sz);
            smm_act_ni = ~au[0]; open_i = au[1];
            glob_en_i = en[0]; hi_en_i = en[1]; rsv_en_i = en[2];
            shadow_i = (sc == 0) ? 3'b000 : (sc == 1) ? 3'b101 : (sc == 2) ? 3'b010 : 3'b111;
            f_resume_i = sc[0];
            clear_err();
            for (int s = 0; s < 16; s++)
              access(ALIAS + 32'(s) * 32'h1_0000 + 32'h0ABC, au[0]);
            for (int k = 0; k < 10; k++) begin
              access(mem_top_i + offs[k], au[0]);
              access(ALIAS + mem_top_i + offs[k], au[0]);
            end
          end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule